// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps wall-clock time in the system clock domain and advances it on a slow, free-running tick, normally 32768 Hz. Time is held as a 32-bit seconds count and a fixed-point fraction of a second. The fraction is 38 bits wide. Its upper 32 bits are the visible subsecond field, and the lower 6 bits stay hidden. On each tick a programmable increment is added to the fraction. A carry out of the fraction advances the seconds count. The increment is the tick-to-fraction scale factor, so trimming it by a given proportion speeds up or slows down the clock by that same proportion. The low bits of a trimmed increment build up in the hidden field and add an occasional one-LSB correction to the visible field.

Software reaches the counter through a small register port. The port lets it load seconds and subseconds and write the increment. It can read seconds, subseconds (through a coherent shadow) and the increment. The full time is also available on a 64-bit output. The tick is asynchronous to the system clock, so it is resynchronised and edge-detected before it advances anything.

Top module: `rtc_frac_counter`

## Requirements
- R1: The time output changes only in the cycle after a synchronised tick edge or a time-register write. Between ticks every read returns the same value.
- R2: After reset the increment is 0x800000. Each tick then adds exactly 0x20000 to the 32-bit subsecond field.
- R3: A carry out of the 38-bit fraction increments seconds on the same tick. Seconds wrap modulo 2^32, so 0xFFFFFFFF.FFFE0000 plus one default tick gives 0.0.
- R4: A write to register address 2 (the increment, low 24 bits of the write data) is used from the next tick on. Address 2 reads back the increment, zero-extended.
- R5: The fraction keeps 6 hidden bits below the subsecond field. With an increment of 0x7FFFC7 and the hidden bits cleared, 10 ticks from subsecond 0 give subsecond 0x13FFF7.
- R6: The 64-bit time output carries seconds in bits 63:32 and subseconds in bits 31:0.
- R7: Reading address 0 (seconds) latches the current subseconds into a shadow. The next read of address 1 (subseconds) returns that shadow even if ticks occurred in between. A read of address 1 with no pending shadow returns the live value.
- R8: A write to address 0 loads seconds, and a write to address 1 loads subseconds. Both writes clear the hidden fraction bits. A time write in the same cycle as a tick takes priority over the tick.
- R9: Each rising edge of the slow tick advances the counter exactly once, however long the tick stays high. The new time is visible by the third system clock edge after the rise.
- R10: A synchronous reset clears seconds, subseconds, hidden bits and the shadow, and sets the increment to 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slowTick | input | 1 | Asynchronous low-frequency tick |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (drives the shadow latch) |
| regAddr | input | 2 | 0 seconds, 1 subseconds, 2 increment |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| timeNow | output | 64 | {seconds, subseconds} |

## Verification
The properties assume that the slow tick stays low and high for at least two system clocks each. They also assume that a read or write strobe lasts a single cycle and names one address. The stimulus holds the tick high for three or more clocks and low for four. It drives each access at a falling edge and removes it right after the next rising edge. Writes never land on a tick edge, so the reference model stays exact. The write-over-tick priority is therefore assumed by the assertions rather than provoked.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    REG_SEC = 2'd0,
    REG_SUB = 2'd1,
    REG_INC = 2'd2,
    REG_RSV = 2'd3
  } regSel_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic tick;
    logic loadSec;
    logic loadSub;
    logic loadInc;
    logic latchShadow;
    logic useShadow;
  } rtcStrobes_t;

endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tickAsync,
  output logic tickPulse
);
  logic [STAGES-1:0] chain;
  logic              lastLevel;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= tickAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= 1'b0;
    else     lastLevel <= chain[STAGES-1];
  end

  assign tickPulse = chain[STAGES-1] & ~lastLevel;
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        slowTick,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  output rtcStrobes_t strb
);
  logic    tickPulse;
  regSel_e sel;

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .tickAsync (slowTick),
    .tickPulse (tickPulse)
  );

  assign sel = regSel_e'(regAddr);

  always_comb begin
    strb             = '0;
    strb.tick        = tickPulse;
    strb.loadSec     = regWrEn && (sel == REG_SEC);
    strb.loadSub     = regWrEn && (sel == REG_SUB);
    strb.loadInc     = regWrEn && (sel == REG_INC);
    strb.latchShadow = regRdEn && (sel == REG_SEC);
    strb.useShadow   = regRdEn && (sel == REG_SUB);
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter int                HID_W   = 6,
  parameter int                INC_W   = 24,
  parameter logic [INC_W-1:0]  INC_DEF = 24'h800000
) (
  input  logic              clk,
  input  logic              rst,
  input  rtcStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] secCur,
  output logic [DATA_W-1:0] subLive,
  output logic [DATA_W-1:0] subShadow,
  output logic              shadowValid,
  output logic [INC_W-1:0]  incCur
);
  localparam int FRAC_W = DATA_W + HID_W;

  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   fracSum;
  logic              timeWrite;

  assign fracSum   = {1'b0, frac} + {{(FRAC_W+1-INC_W){1'b0}}, incCur};
  assign timeWrite = strb.loadSec | strb.loadSub;

  always_ff @(posedge clk) begin
    if (rst) begin
      frac   <= '0;
      secCur <= '0;
    end else if (strb.loadSec) begin
      secCur            <= wrData;
      frac[HID_W-1:0]   <= '0;
    end else if (strb.loadSub) begin
      frac <= {wrData, {HID_W{1'b0}}};
    end else if (strb.tick) begin
      frac   <= fracSum[FRAC_W-1:0];
      secCur <= secCur + {{(DATA_W-1){1'b0}}, fracSum[FRAC_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               incCur <= INC_DEF;
    else if (strb.loadInc) incCur <= wrData[INC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      subShadow   <= '0;
      shadowValid <= 1'b0;
    end else if (strb.latchShadow) begin
      subShadow   <= frac[FRAC_W-1:HID_W];
      shadowValid <= 1'b1;
    end else if (strb.useShadow) begin
      shadowValid <= 1'b0;
    end
  end

  assign subLive = frac[FRAC_W-1:HID_W];

  logic unusedTw;
  assign unusedTw = timeWrite;
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter
  import rtc_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               HID_W       = 6,
  parameter int               INC_W       = 24,
  parameter logic [INC_W-1:0] INC_DEF     = 24'h800000,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slowTick,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [2*DATA_W-1:0] timeNow
);
  rtcStrobes_t       strb;
  logic [DATA_W-1:0] secCur;
  logic [DATA_W-1:0] subLive;
  logic [DATA_W-1:0] subShadow;
  logic              shadowValid;
  logic [INC_W-1:0]  incCur;

  rtc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .slowTick (slowTick),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .strb     (strb)
  );

  rtc_datapath #(
    .DATA_W  (DATA_W),
    .HID_W   (HID_W),
    .INC_W   (INC_W),
    .INC_DEF (INC_DEF)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .wrData      (regWrData),
    .secCur      (secCur),
    .subLive     (subLive),
    .subShadow   (subShadow),
    .shadowValid (shadowValid),
    .incCur      (incCur)
  );

  always_comb begin
    case (regSel_e'(regAddr))
      REG_SEC: regRdData = secCur;
      REG_SUB: regRdData = shadowValid ? subShadow : subLive;
      REG_INC: regRdData = {{(DATA_W-INC_W){1'b0}}, incCur};
      default: regRdData = secCur;
    endcase
  end

  assign timeNow = {secCur, subLive};
endmodule

// File: rtl/rtc_frac_counter_chk.sv
module rtc_frac_counter_chk
  import rtc_pkg::*;
#(
  parameter int               INC_W   = 24,
  parameter logic [INC_W-1:0] INC_DEF = 24'h800000
) (
  input logic             clk,
  input logic             rst,
  input logic             regWrEn,
  input rtcStrobes_t      strb,
  input logic [63:0]      timeNow,
  input logic [INC_W-1:0] incCur
);
  // R1
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.tick && !regWrEn) |=> $stable(timeNow));

  // R2
  default_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && !regWrEn && incCur == INC_DEF)
      |=> timeNow[31:0] == $past(timeNow[31:0]) + 32'h0002_0000);

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && !regWrEn)
      |=> (timeNow[63:32] == $past(timeNow[63:32]) ||
           timeNow[63:32] == $past(timeNow[63:32]) + 32'd1));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strb.tick |=> !strb.tick);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (timeNow == 64'd0 && incCur == INC_DEF));
endmodule

bind rtc_frac_counter rtc_frac_counter_chk #(.INC_W(INC_W), .INC_DEF(INC_DEF)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .regWrEn (regWrEn),
  .strb    (strb),
  .timeNow (timeNow),
  .incCur  (incCur)
);

// File: tb/rtc_frac_counter_tb.sv
`timescale 1ns/1ps
module rtc_frac_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slowTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] timeNow;

  int testsRun = 0;
  int testsFail = 0;

  // reference model
  logic [37:0] expFrac = '0;
  logic [31:0] expSec = '0;
  logic [23:0] expInc = 24'h800000;

  logic [63:0] expQ[$];
  string       tagQ[$];
  logic        monReq = 1'b0;

  always #2.5 clk = ~clk;

  rtc_frac_counter u_dut (
    .clk(clk), .rst(rst), .slowTick(slowTick), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .timeNow(timeNow)
  );

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected time and compares once the driver says it is due
  initial begin
    forever begin
      @(negedge clk);
      if (monReq) begin
        checkEq(tagQ.pop_front(), timeNow, expQ.pop_front());
        monReq = 1'b0;
      end
    end
  end

  task automatic modelTick();
    logic [38:0] s;
    s = {1'b0, expFrac} + {15'd0, expInc};
    expFrac = s[37:0];
    expSec  = expSec + {31'd0, s[38]};
  endtask

  task automatic pulseTick(input int highCycles);
    @(negedge clk);
    slowTick = 1'b1;
    repeat (highCycles) @(posedge clk);
    #1 slowTick = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // driver: one tick, push expectation, wait for the monitor
  task automatic doTick(input string tag, input int highCycles = 3);
    pulseTick(highCycles);
    modelTick();
    expQ.push_back({expSec, expFrac[37:6]});
    tagQ.push_back(tag);
    monReq = 1'b1;
    wait (!monReq);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
    case (a)
      2'd0: begin expSec = d; expFrac[5:0] = 6'd0; end
      2'd1: expFrac = {d, 6'd0};
      2'd2: expInc = d[23:0];
      default: ;
    endcase
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(posedge clk);
    #1 regRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    logic [31:0] r0;
    logic [31:0] r1;
    logic [63:0] t0;
    logic [31:0] subBefore;

    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checkEq("R10 reset time", timeNow, 64'd0);
    rdReg(2'd2, r0);
    checkEq("R10 reset increment", {32'd0, r0}, 64'h800000);

    // default rate and sync timing
    doTick("R2 default tick 1");
    doTick("R2 default tick 2");
    doTick("R9 sync latency tick");
    doTick("R9 long-high tick advances once", 25);

    // stability between ticks
    t0 = timeNow;
    rdReg(2'd1, r0);
    repeat (12) @(posedge clk);
    rdReg(2'd1, r1);
    checkEq("R1 subsec reads equal between ticks", {32'd0, r1}, {32'd0, r0});
    @(negedge clk);
    checkEq("R1 time stable between ticks", timeNow, t0);

    // carry into seconds
    wrReg(2'd1, 32'hFFFC_0000);
    doTick("R3 pre-carry tick");
    doTick("R3 fraction carry into seconds");
    wrReg(2'd0, 32'hFFFF_FFFF);
    wrReg(2'd1, 32'hFFFE_0000);
    doTick("R3 seconds wrap");
    checkEq("R3 wrap to zero", timeNow, 64'd0);

    // trimmed increment and hidden bits
    wrReg(2'd2, 32'h007F_FFC7);
    rdReg(2'd2, r0);
    checkEq("R4 increment readback", {32'd0, r0}, 64'h7FFFC7);
    wrReg(2'd1, 32'd0);
    for (int i = 0; i < 10; i++) doTick("R5 trimmed tick");
    rdReg(2'd1, r0);
    checkEq("R5 hidden carry after 10 ticks", {32'd0, r0}, 64'h13FFF7);

    // hidden bits cleared by subsecond write
    wrReg(2'd1, 32'd0);
    for (int i = 0; i < 9; i++) doTick("R5 hidden fill tick");
    wrReg(2'd1, 32'h0000_0100);
    doTick("R8 load clears hidden bits");
    checkEq("R8 step after load", {32'd0, timeNow[31:0]}, 64'h200FF);

    // increment change used from next tick
    wrReg(2'd2, 32'h0080_0000);
    t0 = timeNow;
    doTick("R4 new increment on next tick");
    checkEq("R4 step size", {32'd0, timeNow[31:0] - t0[31:0]}, 64'h20000);

    // coherent shadow read
    subBefore = timeNow[31:0];
    rdReg(2'd0, r0);
    checkEq("R7 seconds read", {32'd0, r0}, {32'd0, expSec});
    doTick("R7 tick after seconds read");
    rdReg(2'd1, r1);
    checkEq("R7 shadow subseconds", {32'd0, r1}, {32'd0, subBefore});
    rdReg(2'd1, r1);
    checkEq("R7 live subseconds after shadow", {32'd0, r1}, {32'd0, expFrac[37:6]});

    // 64-bit layout
    wrReg(2'd0, 32'h1234_5678);
    wrReg(2'd1, 32'h9ABC_0000);
    rdReg(2'd0, r0);
    rdReg(2'd1, r1);
    @(negedge clk);
    checkEq("R6 time layout", timeNow, {r0, r1});
    checkEq("R6 time value", timeNow, 64'h1234_5678_9ABC_0000);

    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule